// File: doc/BRIEF.md
# Shared-Slave Arbiter with Idle Parking

This block decides which of several bus masters may drive one shared slave. It samples one request line per master and keeps a registered one-hot grant. It also drives an `active` flag that is high in every cycle the slave is serving the granted master. Arbitration is either round-robin or driven by a fixed 2-bit priority per master. Once a master holds the slave, it keeps it until its burst ends. A burst ends when the master marks its final beat or when a programmable slot-cycle budget runs out at a beat boundary.

When the slave has nothing to do, a parking policy chooses where the grant rests. It can drop to nobody, stay with the master that used the slave last, or move to a programmed master. A master that already holds the grant is served in the same cycle it raises its request. Any other master waits one cycle for the registered grant. The block is instantiated once per slave and takes its configuration as static input fields.

Top module: `slv_arbiter`

## Requirements
- R1: After reset, `gnt` is all zero and `active` is low. The round-robin history is set so that master 0 is searched first.
- R2: `gnt` has at most one bit set. `active` is high in exactly those cycles where the granted master also has its request high, with no added delay.
- R3: Parking mode 0 (and the spare code 3): one cycle after all requests are low, `gnt` is zero. A new request then sees `active` low in its first cycle and high one cycle later.
- R4: Parking mode 1: when all requests drop, `gnt` keeps the last owner. That owner's next request raises `active` in the same cycle.
- R5: Parking mode 2: when all requests are low, `gnt` moves to the master numbered by `cfg_park_id`. An id of 5 or more behaves like mode 0.
- R6: With `cfg_fixed_prio`=1, an arbitration picks the requester with the largest 2-bit priority. Master i's priority is `cfg_prio[2i+1:2i]`. On a tie the lowest index wins.
- R7: With `cfg_fixed_prio`=0, an arbitration picks the first requester found by counting upward, with wrap-around, from the master after the last one that won.
- R8: While the owner keeps requesting, the grant does not change until a beat (`beat`=1) arrives with `beat_last`=1, even when higher-ranked masters are waiting. At that point a new arbitration takes place.
- R9: With `cfg_slot`=N>0 and a beat in every cycle, an owner keeps the slave for exactly N cycles of a burst. The grant is re-evaluated only at a beat, so without beats the expired owner keeps it. N=0 places no limit on the burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 5 | Request line per master |
| beat | input | 1 | A data beat of the owner completes this cycle |
| beat_last | input | 1 | The completing beat ends the owner's burst |
| cfg_fixed_prio | input | 1 | 1 selects fixed priority, 0 selects round-robin |
| cfg_prio | input | 10 | 2-bit priority per master, master i at bits 2i+1:2i |
| cfg_slot | input | 8 | Maximum number of cycles per burst, 0 for no limit |
| cfg_park_mode | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed master |
| cfg_park_id | input | 3 | Master index used by parking mode 2 |
| gnt | output | 5 | Registered one-hot grant |
| active | output | 1 | The slave is serving the granted master this cycle |

## Verification
Fixed priority is swept over every non-empty request pattern under four priority maps: all ties, ascending, descending and mixed. This tells the largest-value rule apart from the tie-break toward the lowest index. Round-robin is swept over every request pattern for each possible last winner, which exposes any off-by-one in where the search starts and how it wraps. Burst tests hold two competing masters with steady beats, with no beats, with a last-beat marker and with slot budgets of 0, 2 and 3. These separate burst holding, slot expiry and the gating at beat boundaries. The parking tests watch `active` in the very cycle a request rises, which shows the one-cycle difference between a parked owner and a master that starts with no grant.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_SPARE = 2'd3
  } park_mode_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NM = 5,
  parameter int PW = 2
) (
  input  logic [NM-1:0]    req,
  input  logic [NM*PW-1:0] prio,
  output logic [NM-1:0]    pick
);
  logic          found;
  logic [PW-1:0] best;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    best  = '0;
    // scan downward; ">=" lets a lower index take over on a tie
    for (int i = NM - 1; i >= 0; i--) begin
      if (req[i] && (!found || prio[i*PW +: PW] >= best)) begin
        found   = 1'b1;
        best    = prio[i*PW +: PW];
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    assert_prio_pick_in_req_R6: assert ((pick & ~req) == '0);
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NM = 5,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NM-1:0] req,
  input  logic [IW-1:0] last_idx,
  output logic [NM-1:0] pick
);
  logic          found;
  logic [IW-1:0] cand;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    cand  = '0;
    for (int k = 1; k <= NM; k++) begin
      cand = IW'((int'(last_idx) + k) % NM);
      if (!found && req[cand]) begin
        found      = 1'b1;
        pick[cand] = 1'b1;
      end
    end
  end

  always_comb begin
    assert_rr_pick_in_req_R7: assert ((pick & ~req) == '0);
  end
endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [SW-1:0] slot,
  output logic          expired
);
  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // cnt_q counts cycles already held; the current cycle is number cnt_q+1
  assign expired = (slot != '0) && (cnt_q >= slot - SW'(1));

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != '1));
    cnt_d  = clr ? '0 : cnt_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_slot_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/slv_arbiter.sv
module slv_arbiter
  import slv_arb_pkg::*;
#(
  parameter int NM = 5,
  parameter int PW = 2,
  parameter int SW = 8,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    req,
  input  logic             beat,
  input  logic             beat_last,
  input  logic             cfg_fixed_prio,
  input  logic [NM*PW-1:0] cfg_prio,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [1:0]       cfg_park_mode,
  input  logic [IW-1:0]    cfg_park_id,
  output logic [NM-1:0]    gnt,
  output logic             active
);
  logic [NM-1:0] gnt_q, gnt_d;
  logic [IW-1:0] last_q, last_d;
  logic [NM-1:0] rr_pick, pr_pick, win, park_vec;
  logic [IW-1:0] win_idx;
  logic          owner_req, slot_exp, burst_end, rearb, any_req, last_en;
  park_mode_e    park_mode;

  assign park_mode = park_mode_e'(cfg_park_mode);
  assign owner_req = |(gnt_q & req);
  assign any_req   = |req;
  assign burst_end = beat && (beat_last || slot_exp);
  assign rearb     = !owner_req || burst_end;

  arb_rr_pick #(.NM(NM)) u_rr (
    .req(req), .last_idx(last_q), .pick(rr_pick)
  );

  arb_prio_pick #(.NM(NM), .PW(PW)) u_prio (
    .req(req), .prio(cfg_prio), .pick(pr_pick)
  );

  arb_slot_timer #(.SW(SW)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(rearb), .inc(owner_req),
    .slot(cfg_slot), .expired(slot_exp)
  );

  assign win = cfg_fixed_prio ? pr_pick : rr_pick;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NM; i++) begin
      if (win[i]) win_idx = IW'(i);
    end
  end

  always_comb begin
    park_vec = '0;
    case (park_mode)
      PARK_LAST:  park_vec = gnt_q;
      PARK_FIXED: if (int'(cfg_park_id) < NM) park_vec[cfg_park_id] = 1'b1;
      default:    park_vec = '0;
    endcase
  end

  always_comb begin
    gnt_d   = gnt_q;
    last_en = 1'b0;
    last_d  = win_idx;
    if (rearb) begin
      if (any_req) begin
        gnt_d   = win;
        last_en = 1'b1;
      end else begin
        gnt_d   = park_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= IW'(NM - 1);
    else if (last_en) last_q <= last_d;
  end

  assign gnt    = gnt_q;
  assign active = owner_req;

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  assert_active_needs_gnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((gnt_q & req) != '0));

  assert_burst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_req && !beat) |=> $stable(gnt_q));

  assert_park_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_park_mode == 2'd0) && (req == '0)) |=> (gnt_q == '0));

  assert_park_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_park_mode == 2'd1) && (req == '0)) |=> $stable(gnt_q));

  assert_park_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_park_mode == 2'd2) && (req == '0) && (int'(cfg_park_id) < NM))
      |=> (gnt_q == (NM'(1) << $past(cfg_park_id))));
endmodule

// File: tb/slv_arbiter_tb.sv
`timescale 1ns/1ps
module slv_arbiter_tb;
  localparam int NM = 5;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NM-1:0]  req;
  logic           beat, beat_last, cfg_fixed_prio;
  logic [2*NM-1:0] cfg_prio;
  logic [7:0]     cfg_slot;
  logic [1:0]     cfg_park_mode;
  logic [2:0]     cfg_park_id;
  logic [NM-1:0]  gnt;
  logic           active;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  slv_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .beat(beat), .beat_last(beat_last),
    .cfg_fixed_prio(cfg_fixed_prio), .cfg_prio(cfg_prio), .cfg_slot(cfg_slot),
    .cfg_park_mode(cfg_park_mode), .cfg_park_id(cfg_park_id),
    .gnt(gnt), .active(active)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_fixed(input int r, input logic [2*NM-1:0] p);
    int best = -1;
    int sel  = 0;
    for (int i = 0; i < NM; i++) begin
      if (r[i] && int'(p[2*i +: 2]) > best) begin
        best = int'(p[2*i +: 2]);
        sel  = 1 << i;
      end
    end
    return sel;
  endfunction

  function automatic int exp_rr(input int r, input int last);
    for (int k = 1; k <= NM; k++) begin
      if (r[(last + k) % NM]) return 1 << ((last + k) % NM);
    end
    return 0;
  endfunction

  // hands m0 the slave with m0 and m1 both requesting (history set to m4)
  task automatic seat_m0();
    req = 5'b10000; step();
    req = 5'b00000; step();
    req = 5'b00011; step();
  endtask

  initial begin
    logic [2*NM-1:0] maps [4];
    int n;
    maps[0] = '0;
    maps[1] = {2'd0, 2'd3, 2'd2, 2'd1, 2'd0};
    maps[2] = {2'd0, 2'd1, 2'd2, 2'd3, 2'd3};
    maps[3] = {2'd2, 2'd0, 2'd3, 2'd1, 2'd3};

    rst_n = 1'b0; req = '0; beat = 1'b1; beat_last = 1'b0;
    cfg_fixed_prio = 1'b1; cfg_prio = '0; cfg_slot = '0;
    cfg_park_mode = 2'd0; cfg_park_id = '0;
    repeat (3) step();
    chk("R1 gnt after reset", int'(gnt), 0);
    chk("R1 active after reset", int'(active), 0);
    rst_n = 1'b1;
    step();

    // R6 fixed-priority sweep
    for (int m = 0; m < 4; m++) begin
      cfg_prio = maps[m];
      for (int p = 1; p < 32; p++) begin
        req = '0; step();
        req = NM'(p); #1;
        chk("R3 no grant in first cycle", int'(active), 0);
        step();
        chk("R6 fixed winner", int'(gnt), exp_fixed(p, maps[m]));
        chk("R2 active when granted", int'(active), 1);
      end
    end

    // R7 round-robin sweep over every last winner
    cfg_fixed_prio = 1'b0;
    for (int l = 0; l < NM; l++) begin
      for (int p = 1; p < 32; p++) begin
        req = NM'(1 << l); step();
        req = '0; step();
        chk("R3 idle grant zero", int'(gnt), 0);
        req = NM'(p); step();
        chk("R7 round-robin winner", int'(gnt), exp_rr(p, l));
      end
    end

    // R9 slot of 3 with a beat each cycle
    cfg_slot = 8'd3; beat = 1'b1; beat_last = 1'b0;
    seat_m0();
    chk("R9 m0 seated", int'(gnt), 1);
    n = 1;
    for (int c = 0; c < 10; c++) begin
      step();
      if (gnt != 5'b00001) break;
      n++;
    end
    chk("R9 m0 held cycles", n, 3);
    chk("R9 handover to m1", int'(gnt), 2);
    n = 1;
    for (int c = 0; c < 10; c++) begin
      step();
      if (gnt != 5'b00010) break;
      n++;
    end
    chk("R9 m1 held cycles", n, 3);
    chk("R9 back to m0", int'(gnt), 1);

    // R9 slot 0 means no limit
    cfg_slot = 8'd0;
    seat_m0();
    n = 0;
    for (int c = 0; c < 20; c++) begin
      step();
      if (gnt == 5'b00001) n++;
    end
    chk("R9 unlimited hold", n, 20);

    // R9 expiry waits for a beat
    cfg_slot = 8'd2;
    seat_m0();
    beat = 1'b0;
    n = 0;
    for (int c = 0; c < 6; c++) begin
      step();
      if (gnt == 5'b00001) n++;
    end
    chk("R9 no beat keeps owner", n, 6);
    beat = 1'b1; step();
    chk("R9 beat releases", int'(gnt), 2);

    // R8 last beat ends the burst (round-robin)
    cfg_slot = 8'd0;
    seat_m0();
    for (int c = 0; c < 5; c++) step();
    chk("R8 burst holds", int'(gnt), 1);
    beat_last = 1'b1; step(); beat_last = 1'b0;
    chk("R8 last beat rearbitrates", int'(gnt), 2);

    // R8 higher priority waits for the end of the burst
    cfg_fixed_prio = 1'b1;
    cfg_prio = {2'd3, 2'd0, 2'd0, 2'd0, 2'd0};
    req = '0; step();
    req = 5'b00001; step();
    req = 5'b10001;
    for (int c = 0; c < 3; c++) step();
    chk("R8 owner not preempted", int'(gnt), 1);
    beat_last = 1'b1; step(); beat_last = 1'b0;
    chk("R8 high priority after burst", int'(gnt), 16);

    // R4 park on last owner
    cfg_park_mode = 2'd1;
    req = 5'b00100; step();
    req = '0; step(); step();
    chk("R4 parked on last owner", int'(gnt), 4);
    req = 5'b00100; #1;
    chk("R4 zero-wait access", int'(active), 1);
    req = 5'b01000; #1;
    chk("R4 other master waits", int'(active), 0);
    step();
    chk("R4 other master granted", int'(gnt), 8);

    // R3 spare parking code behaves as none
    cfg_park_mode = 2'd3;
    req = '0; step();
    chk("R3 spare code idles to zero", int'(gnt), 0);

    // R5 fixed parking for every id, then an out-of-range id
    cfg_park_mode = 2'd2;
    for (int id = 0; id < NM; id++) begin
      cfg_park_id = 3'(id);
      req = '0; step();
      chk("R5 parked on fixed id", int'(gnt), 1 << id);
      req = NM'(1 << id); #1;
      chk("R5 parked master served at once", int'(active), 1);
    end
    cfg_park_id = 3'd6;
    req = '0; step();
    chk("R5 bad id idles to zero", int'(gnt), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule